// File: doc/BRIEF.md
# Real-Time Counter with Shadowed Seconds Readout

This block keeps wall-clock time as a seconds count and a milliseconds count, both advanced by a slow reference tick that is nominally 32.768 kHz. The tick arrives as a single-cycle enable in the bus clock domain. A fractional accumulator turns the tick rate into exact milliseconds. Whenever the milliseconds count wraps, the seconds count advances by one.

The bus never sees the running counters directly. After every eighth tick the block opens a short busy window. At the end of that window it copies the counters into a bus-visible view. Any write that arrives while the window is open is dropped, so software first waits for busy to clear and then has the rest of the eight-tick period to make its change. A read of the milliseconds register also copies the seconds value from the same view into a shadow register. A later shadow read therefore returns a seconds/milliseconds pair taken at one instant, even if the seconds value moves on in between.

A single seconds alarm compares against the counter at each seconds step. A hit sets a sticky status bit, which software clears by writing a 1 to it. A level interrupt is raised while any status bit and its mask bit are both set.

Top module: `rtc_shadow_counter`

## Requirements
- R1: After reset, every register reads 0: busy at 0x04, seconds at 0x08, shadow at 0x0C, milliseconds at 0x10, alarm at 0x14, mask at 0x28 and status at 0x2C. The irq output is 0.
- R2: Each tick adds MS_PER_S to an accumulator. Each time the accumulator reaches TICK_HZ, TICK_HZ is subtracted and the milliseconds count advances. Milliseconds run from 0 to MS_PER_S-1. The step from MS_PER_S-1 back to 0 advances seconds by one.
- R3: The seconds value read at 0x08 and the milliseconds value read at 0x10 change only in two cases: when the busy window after every POST_TICKS-th tick since reset ends, which copies in the running counters, or on an accepted seconds write.
- R4: Bit 0 of register 0x04 reads 1 for POST_CYCLES bus cycles. The window starts at the edge that samples the posting tick.
- R5: A read of 0x10 copies the currently visible seconds value into the shadow register at 0x0C. The shadow keeps that value until the next read of 0x10.
- R6: An accepted write to 0x08 loads the seconds counter and clears both the milliseconds count and the accumulator. The new value reads back at once, with milliseconds 0.
- R7: Any write issued while busy is 1 is ignored, and the targeted register keeps its old value.
- R8: When seconds steps to a value equal to the alarm register at 0x14 (read/write), status bit 0 is set. An alarm value of 0 never sets the bit, including when seconds wraps to 0.
- R9: Writing 1 to a bit of register 0x2C clears that bit. Writing 0 leaves it unchanged. A new alarm event in the same cycle as a clear takes priority and keeps the bit set.
- R10: irq is 1 exactly while the AND of status and mask (0x28) is non-zero. Only bit 0 (seconds alarm) is implemented in either register. Bits 1 to 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable per reference tick |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; data valid after the next edge |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Active-high level interrupt |

## Verification
A fault in the accumulator or the milliseconds counter does not appear at the ports straight away. It shows up as a wrong seconds or milliseconds value at the next posting, which comes at most eight ticks later. An alarm fault shows up as a wrong status bit or irq level about two cycles after the seconds step. A corrupted shadow or busy state, or a wrong write-acceptance decision, shows up at the very next read of the affected register. The directed sequences therefore read back after every posting boundary, in the middle of a busy window, and across a seconds step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int RTC_SEC_W  = 32;
    localparam int RTC_MS_W   = 16;
    localparam int RTC_DATA_W = 32;
    localparam int RTC_ADDR_W = 8;
    localparam int RTC_IRQ_W  = 5;

    localparam logic [RTC_ADDR_W-1:0] ADR_BUSY   = 8'h04;
    localparam logic [RTC_ADDR_W-1:0] ADR_SEC    = 8'h08;
    localparam logic [RTC_ADDR_W-1:0] ADR_SHADOW = 8'h0C;
    localparam logic [RTC_ADDR_W-1:0] ADR_MS     = 8'h10;
    localparam logic [RTC_ADDR_W-1:0] ADR_ALARM  = 8'h14;
    localparam logic [RTC_ADDR_W-1:0] ADR_MASK   = 8'h28;
    localparam logic [RTC_ADDR_W-1:0] ADR_STATUS = 8'h2C;

    // interrupt bit positions; only the seconds alarm is built
    localparam int IRQ_ALARM0 = 0;
    localparam logic [RTC_IRQ_W-1:0] IRQ_IMPL = 5'b00001;

    typedef struct packed {
        logic [RTC_SEC_W-1:0] sec;
        logic [RTC_MS_W-1:0]  ms;
    } rtc_time_t;

    function automatic logic [RTC_DATA_W-1:0] widen_ms(input logic [RTC_MS_W-1:0] m);
        return {{(RTC_DATA_W-RTC_MS_W){1'b0}}, m};
    endfunction

    function automatic logic [RTC_DATA_W-1:0] widen_irq(input logic [RTC_IRQ_W-1:0] v);
        return {{(RTC_DATA_W-RTC_IRQ_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/rtc_tick_core.sv
module rtc_tick_core
    import rtc_pkg::*;
#(
    parameter int TICK_HZ  = 32768,
    parameter int MS_PER_S = 1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 load_en,
    input  logic [RTC_SEC_W-1:0] load_sec,
    input  logic [RTC_SEC_W-1:0] alarm_sec,
    output rtc_time_t            now,
    output logic                 alarm_hit
);

    localparam int ACC_W = $clog2(TICK_HZ + MS_PER_S) + 1;
    localparam logic [ACC_W-1:0]    ACC_INC = ACC_W'(MS_PER_S);
    localparam logic [ACC_W-1:0]    ACC_TOP = ACC_W'(TICK_HZ);
    localparam logic [RTC_MS_W-1:0] MS_LAST = RTC_MS_W'(MS_PER_S - 1);

    logic [ACC_W-1:0]     acc_q;
    logic [ACC_W-1:0]     acc_sum;
    logic [ACC_W-1:0]     acc_next;
    logic                 ms_step;
    logic                 ms_wrap;
    logic [RTC_SEC_W-1:0] sec_inc;
    rtc_time_t            now_q;

    always_comb begin
        acc_sum  = acc_q + ACC_INC;
        ms_step  = (acc_sum >= ACC_TOP);
        acc_next = ms_step ? (acc_sum - ACC_TOP) : acc_sum;
        ms_wrap  = ms_step && (now_q.ms == MS_LAST);
        sec_inc  = now_q.sec + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            now_q     <= '0;
            alarm_hit <= 1'b0;
        end else begin
            alarm_hit <= 1'b0;
            if (load_en) begin
                now_q.sec <= load_sec;
                now_q.ms  <= '0;
                acc_q     <= '0;
            end else if (tick) begin
                acc_q <= acc_next;
                if (ms_wrap) begin
                    now_q.ms  <= '0;
                    now_q.sec <= sec_inc;
                    alarm_hit <= (alarm_sec != '0) && (sec_inc == alarm_sec);
                end else if (ms_step) begin
                    now_q.ms <= now_q.ms + 1'b1;
                end
            end
        end
    end

    assign now = now_q;

    // R2: milliseconds never leave their range
    assert_ms_range_R2: assert property (@(posedge clk) disable iff (rst)
        now_q.ms <= MS_LAST);

    // R2: seconds move only together with a milliseconds wrap, or on a load
    assert_sec_on_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(load_en) && (now_q.sec != $past(now_q.sec))) |-> (now_q.ms == '0));

    // R8: a zero alarm register never produces a hit
    assert_alarm_zero_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(alarm_sec) == '0) |-> !alarm_hit);

endmodule

// File: rtl/rtc_post_ctrl.sv
module rtc_post_ctrl #(
    parameter int POST_TICKS  = 8,
    parameter int POST_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic busy,
    output logic post_stb
);

    localparam int TCNT_W = $clog2(POST_TICKS + 1);
    localparam int BCNT_W = $clog2(POST_CYCLES + 1);
    localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(POST_TICKS - 1);
    localparam logic [BCNT_W-1:0] BCNT_LOAD = BCNT_W'(POST_CYCLES - 1);

    logic [TCNT_W-1:0] tick_cnt_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic              busy_q;
    logic              start;

    assign start = tick && (tick_cnt_q == TCNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt_q <= '0;
            busy_q     <= 1'b0;
            bcnt_q     <= '0;
        end else begin
            if (tick) begin
                tick_cnt_q <= start ? '0 : tick_cnt_q + 1'b1;
            end
            if (start) begin
                busy_q <= 1'b1;
                bcnt_q <= BCNT_LOAD;
            end else if (busy_q) begin
                if (bcnt_q == '0) begin
                    busy_q <= 1'b0;
                end else begin
                    bcnt_q <= bcnt_q - 1'b1;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign post_stb = busy_q && (bcnt_q == '0) && !start;

    // checker counter for the busy window length
    localparam int RUN_W = BCNT_W + 1;
    logic [RUN_W-1:0] busy_run_q;
    always_ff @(posedge clk) begin
        if (rst || !busy_q) begin
            busy_run_q <= '0;
        end else if (busy_run_q != '1) begin
            busy_run_q <= busy_run_q + 1'b1;
        end
    end

    // R4: the busy window lasts at least POST_CYCLES cycles
    assert_busy_window_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (busy_run_q >= RUN_W'(POST_CYCLES)));

    // R3: a posting always ends the busy window on the following edge
    assert_post_ends_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (post_stb && !tick) |=> !busy_q);

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [RTC_ADDR_W-1:0] wr_addr,
    input  logic [RTC_DATA_W-1:0] wr_data,
    input  logic                  rd_en,
    input  logic [RTC_ADDR_W-1:0] rd_addr,
    input  logic                  busy,
    input  logic                  post_stb,
    input  rtc_time_t             core_now,
    input  logic                  alarm_hit,
    output logic [RTC_DATA_W-1:0] rd_data,
    output logic                  irq,
    output logic                  load_en,
    output logic [RTC_SEC_W-1:0]  load_sec,
    output logic [RTC_SEC_W-1:0]  alarm_sec
);

    logic                  wr_ok;
    logic                  mask_we;
    logic                  stat_we;
    logic                  alarm_we;
    rtc_time_t             view_q;
    logic [RTC_SEC_W-1:0]  shadow_q;
    logic [RTC_SEC_W-1:0]  alarm_q;
    logic [RTC_IRQ_W-1:0]  mask_q;
    logic [RTC_IRQ_W-1:0]  status_q;
    logic [RTC_IRQ_W-1:0]  evt;
    logic [RTC_DATA_W-1:0] rd_q;

    always_comb begin
        wr_ok    = wr_en && !busy;
        load_en  = wr_ok && (wr_addr == ADR_SEC);
        alarm_we = wr_ok && (wr_addr == ADR_ALARM);
        mask_we  = wr_ok && (wr_addr == ADR_MASK);
        stat_we  = wr_ok && (wr_addr == ADR_STATUS);
        load_sec = wr_data[RTC_SEC_W-1:0];
        evt      = '0;
        evt[IRQ_ALARM0] = alarm_hit;
    end

    // bus-side view of the counters and the shadow seconds
    always_ff @(posedge clk) begin
        if (rst) begin
            view_q   <= '0;
            shadow_q <= '0;
            alarm_q  <= '0;
        end else begin
            if (load_en) begin
                view_q.sec <= wr_data[RTC_SEC_W-1:0];
                view_q.ms  <= '0;
            end else if (post_stb) begin
                view_q <= core_now;
            end
            if (rd_en && (rd_addr == ADR_MS)) begin
                shadow_q <= view_q.sec;
            end
            if (alarm_we) begin
                alarm_q <= wr_data[RTC_SEC_W-1:0];
            end
        end
    end

    // per-bit mask and sticky status; unbuilt bits are tied off
    for (genvar b = 0; b < RTC_IRQ_W; b++) begin : g_irq
        if (IRQ_IMPL[b]) begin : g_impl
            logic m_bit;
            logic s_bit;
            always_ff @(posedge clk) begin
                if (rst) begin
                    m_bit <= 1'b0;
                    s_bit <= 1'b0;
                end else begin
                    if (mask_we) begin
                        m_bit <= wr_data[b];
                    end
                    s_bit <= evt[b] | (s_bit & ~(stat_we & wr_data[b]));
                end
            end
            assign mask_q[b]   = m_bit;
            assign status_q[b] = s_bit;
        end else begin : g_rsvd
            assign mask_q[b]   = 1'b0;
            assign status_q[b] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                ADR_BUSY:   rd_q <= {{(RTC_DATA_W-1){1'b0}}, busy};
                ADR_SEC:    rd_q <= RTC_DATA_W'(view_q.sec);
                ADR_SHADOW: rd_q <= RTC_DATA_W'(shadow_q);
                ADR_MS:     rd_q <= widen_ms(view_q.ms);
                ADR_ALARM:  rd_q <= RTC_DATA_W'(alarm_q);
                ADR_MASK:   rd_q <= widen_irq(mask_q);
                ADR_STATUS: rd_q <= widen_irq(status_q);
                default:    rd_q <= '0;
            endcase
        end
    end

    assign rd_data   = rd_q;
    assign irq       = |(status_q & mask_q);
    assign alarm_sec = alarm_q;

    // R3: the visible counters move only on a posting or an accepted load
    assert_view_source_R3: assert property (@(posedge clk) disable iff (rst)
        (view_q != $past(view_q)) |-> $past(post_stb || load_en));

    // R5: shadow holds unless milliseconds are read
    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && (rd_addr == ADR_MS)) |=> $stable(shadow_q));

    // R7: writes during busy leave the alarm and mask untouched
    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> ($stable(alarm_q) && $stable(mask_q)));

    // R9: a write of 1 clears the alarm status unless a new hit arrives
    assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_we && wr_data[IRQ_ALARM0] && !alarm_hit) |=> !status_q[IRQ_ALARM0]);

    // R10: no interrupt without a pending status bit
    assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (rst)
        (status_q == '0) |-> !irq);

endmodule

// File: rtl/rtc_shadow_counter.sv
module rtc_shadow_counter
    import rtc_pkg::*;
#(
    parameter int TICK_HZ     = 32768,
    parameter int MS_PER_S    = 1000,
    parameter int POST_TICKS  = 8,
    parameter int POST_CYCLES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_tick,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        irq
);

    logic                 busy;
    logic                 post_stb;
    logic                 load_en;
    logic [RTC_SEC_W-1:0] load_sec;
    logic [RTC_SEC_W-1:0] alarm_sec;
    logic                 alarm_hit;
    rtc_time_t            core_now;

    rtc_tick_core #(
        .TICK_HZ  (TICK_HZ),
        .MS_PER_S (MS_PER_S)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (slow_tick),
        .load_en   (load_en),
        .load_sec  (load_sec),
        .alarm_sec (alarm_sec),
        .now       (core_now),
        .alarm_hit (alarm_hit)
    );

    rtc_post_ctrl #(
        .POST_TICKS  (POST_TICKS),
        .POST_CYCLES (POST_CYCLES)
    ) u_post (
        .clk      (clk),
        .rst      (rst),
        .tick     (slow_tick),
        .busy     (busy),
        .post_stb (post_stb)
    );

    rtc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .post_stb  (post_stb),
        .core_now  (core_now),
        .alarm_hit (alarm_hit),
        .rd_data   (rd_data),
        .irq       (irq),
        .load_en   (load_en),
        .load_sec  (load_sec),
        .alarm_sec (alarm_sec)
    );

endmodule

// File: tb/test_rtc_shadow_counter.sv
module test_rtc_shadow_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] A_BUSY = 8'h04, A_SEC = 8'h08, A_SHD = 8'h0C,
                           A_MS = 8'h10, A_ALM = 8'h14, A_MSK = 8'h28,
                           A_STS = 8'h2C;

    // 50 MHz
    always #10 clk = ~clk;

    rtc_shadow_counter #(
        .TICK_HZ     (32),
        .MS_PER_S    (4),
        .POST_TICKS  (8),
        .POST_CYCLES (3)
    ) i_rtc_shadow_counter (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    // ticks to add, then expected visible seconds and milliseconds
    typedef struct packed { logic [31:0] n; logic [31:0] sec; logic [31:0] ms; } vec_t;
    localparam vec_t VECS [6] = '{
        '{32'd8,  32'd0, 32'd1},
        '{32'd8,  32'd0, 32'd2},
        '{32'd16, 32'd1, 32'd0},
        '{32'd5,  32'd1, 32'd0},
        '{32'd3,  32'd1, 32'd1},
        '{32'd24, 32'd2, 32'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_BUSY, v); check("R1 busy", v, 0);
        rd(A_SEC, v);  check("R1 sec", v, 0);
        rd(A_SHD, v);  check("R1 shadow", v, 0);
        rd(A_MS, v);   check("R1 ms", v, 0);
        rd(A_ALM, v);  check("R1 alarm", v, 0);
        rd(A_MSK, v);  check("R1 mask", v, 0);
        rd(A_STS, v);  check("R1 status", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 / R3 vector walk: fractional divider and posting boundaries
        for (int k = 0; k < 6; k++) begin
            ticks(int'(VECS[k].n));
            rd(A_SEC, v); check("R2 R3 vector sec", v, VECS[k].sec);
            rd(A_MS, v);  check("R2 R3 vector ms", v, VECS[k].ms);
        end

        // R5 shadow coherence across a seconds step
        rd(A_MS, v);
        ticks(32);
        rd(A_SHD, v); check("R5 shadow held", v, 2);
        rd(A_SEC, v); check("R5 sec moved", v, 3);
        rd(A_MS, v);
        rd(A_SHD, v); check("R5 shadow relatched", v, 3);

        // R6 seconds load
        wr(A_SEC, 32'd100);
        rd(A_SEC, v); check("R6 sec load", v, 100);
        rd(A_MS, v);  check("R6 ms cleared", v, 0);
        ticks(8);
        rd(A_MS, v);  check("R6 ms after load", v, 1);

        // R4 / R7 busy window and dropped write
        ticks(7);
        @(negedge clk); slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0;
        wr_en = 1'b1; wr_addr = A_SEC; wr_data = 32'd555;
        @(negedge clk); wr_en = 1'b0;
        rd_en = 1'b1; rd_addr = A_BUSY;
        @(negedge clk); rd_en = 1'b0;
        check("R4 busy high", rd_data, 1);
        repeat (5) @(negedge clk);
        rd(A_BUSY, v); check("R4 busy clear", v, 0);
        rd(A_SEC, v);  check("R7 write dropped", v, 100);
        rd(A_MS, v);   check("R7 ms kept", v, 2);

        // R8 / R9 / R10 alarm, status and interrupt
        wr(A_ALM, 32'd101);
        wr(A_MSK, 32'h1F);
        rd(A_ALM, v); check("R8 alarm readback", v, 101);
        rd(A_MSK, v); check("R10 mask reserved bits", v, 1);
        ticks(16);
        rd(A_SEC, v); check("R8 sec at alarm", v, 101);
        rd(A_STS, v); check("R8 status set", v, 1);
        check("R10 irq high", {31'b0, irq}, 1);
        wr(A_STS, 32'h0);
        rd(A_STS, v); check("R9 write zero keeps", v, 1);
        wr(A_MSK, 32'h0);
        check("R10 irq masked", {31'b0, irq}, 0);
        wr(A_MSK, 32'h1);
        check("R10 irq unmasked", {31'b0, irq}, 1);
        wr(A_STS, 32'h1);
        rd(A_STS, v); check("R9 w1c clears", v, 0);
        check("R10 irq low", {31'b0, irq}, 0);

        // R8 zero alarm never fires, even on wrap to 0
        wr(A_ALM, 32'h0);
        wr(A_SEC, 32'hFFFF_FFFF);
        ticks(32);
        rd(A_SEC, v); check("R8 sec wrapped", v, 0);
        rd(A_STS, v); check("R8 zero alarm silent", v, 0);
        check("R8 irq quiet", {31'b0, irq}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule